// File: doc/BRIEF.md
# Sector clock and set/reset distribution column

This block models one column of a configurable logic array, down to the level of a four-cell sector. A column clock selector picks one line out of a set of global clock lines. A column at the left or right edge of the array also offers two fast clock inputs to that selector. The sector then takes its clock either from this column clock or from a local express line. The chosen clock can be inverted or switched off before it reaches the cell registers. A shared active-low set/reset follows the same pattern: it comes from a global line or a second express line, with optional inversion. A per-cell bit decides whether that set/reset drives the cell to 1 or to 0.

All selection and polarity controls are static configuration ports. A configuration-valid input marks the moment configuration takes effect. Until then the sector clock stays at 0 and every register keeps its power-up value of 1. The active-low `rst_ni` models power-up and puts every cell into the set state.

Top module: `col_sector_ctl`

## Requirements
- R1: With `col_sel_i` set to k in the range 0 to 7 and the column source chosen (`grp_clk_src_i`=0), the sector clock follows `gclk_i[k]`.
- R2: When `EDGE_COL`=1, selector codes 8 and 9 pick `fclk_i[0]` and `fclk_i[1]`. When `EDGE_COL`=0, any code of 8 or above gives a constant-0 column clock, and no cell is clocked through it.
- R3: `grp_clk_src_i`=1 takes the sector clock from `xclk_i` and ignores the column selector.
- R4: `clk_inv_i`=1 inverts the chosen source. Cells load `d_i` on each rising edge of the clock that is delivered on `cell_clk_o`, which means they load on the falling edge of the source when it is inverted.
- R5: `clk_en_i`=0 holds `cell_clk_o` at 0, and the cells keep their value whatever the clock lines do.
- R6: While `cfg_valid_i`=0, `cell_clk_o` is 0, the set/reset lines have no effect, and the cells hold their value (1 after power-up).
- R7: The sector set/reset is taken from `xsr_i` when `sr_src_i`=1 and from `gsr_i` otherwise. It is XORed with `sr_inv_i`, and a 0 after the XOR means asserted.
- R8: While the sector set/reset is asserted, cell k is forced at once, with no clock edge needed, to `sr_mode_i[k]` (1 means set, 0 means reset). It stays forced through clock edges for as long as the set/reset is asserted.
- R9: `rst_ni`=0 forces every cell to 1 at once. This overrides clock and set/reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Power-up reset, active low, asynchronous; sets all cells |
| cfg_valid_i | input | 1 | Configuration applied |
| col_sel_i | input | SEL_W | Column clock selector code |
| grp_clk_src_i | input | 1 | Sector clock source: 0 column clock, 1 express line |
| clk_en_i | input | 1 | Sector clock enable |
| clk_inv_i | input | 1 | Sector clock inversion |
| sr_src_i | input | 1 | Set/reset source: 0 global, 1 express line |
| sr_inv_i | input | 1 | Set/reset inversion |
| sr_mode_i | input | CELLS | Per cell: 1 set, 0 reset |
| gclk_i | input | N_GCLK | Global clock lines |
| fclk_i | input | N_FCLK | Fast clock lines (edge columns only) |
| xclk_i | input | 1 | Express clock line |
| gsr_i | input | 1 | Global set/reset line |
| xsr_i | input | 1 | Express set/reset line |
| d_i | input | CELLS | Cell data inputs |
| q_o | output | CELLS | Cell register outputs |
| cell_clk_o | output | 1 | Clock delivered to the sector cells |

## Verification
The bench runs an edge column and an interior column side by side. This exposes a selector that lets codes 8 and 9 through on an interior column, or that drops the fast lines on an edge column: both would clock cells the model leaves untouched. Set/reset changes and clock-line changes are applied in separate steps. A flop whose set/reset is synchronous would then show a stale value right after assertion. Holding the set/reset through clock activity catches a register that gives data priority. Mixed `sr_mode_i` patterns catch a set/reset polarity that is shared or swapped across the cells. Inverted-clock runs catch a design that samples on the source's rising edge, and unconfigured runs with busy lines catch a clock or set/reset that leaks before `cfg_valid_i`.

// File: rtl/col_sector_pkg.sv
package col_sector_pkg;
  typedef enum logic {
    SRC_COLUMN  = 1'b0,
    SRC_EXPRESS = 1'b1
  } src_sel_e;

  function automatic int sel_count(input int n_gclk, input int n_fclk, input bit edge_col);
    return edge_col ? n_gclk + n_fclk : n_gclk;
  endfunction
endpackage

// File: rtl/col_clk_mux.sv
module col_clk_mux #(
  parameter int N_GCLK   = 8,
  parameter int N_FCLK   = 2,
  parameter bit EDGE_COL = 1'b0,
  parameter int SEL_W    = 4
) (
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [N_GCLK-1:0] gclk_i,
  input  logic [N_FCLK-1:0] fclk_i,
  output logic              col_clk_o
);
  localparam int N_IN = col_sector_pkg::sel_count(N_GCLK, N_FCLK, EDGE_COL);

  logic [N_IN-1:0] lines;

  generate
    if (EDGE_COL) begin : g_edge
      assign lines = {fclk_i, gclk_i};
    end else begin : g_inner
      logic unused_fclk;
      assign unused_fclk = ^fclk_i;
      assign lines = gclk_i;
    end
  endgenerate

  // codes past the last line give a quiet 0
  always_comb begin
    col_clk_o = 1'b0;
    for (int k = 0; k < N_IN; k++) begin
      if (sel_i == SEL_W'(k)) col_clk_o = lines[k];
    end
  end
endmodule

// File: rtl/grp_clk_gate.sv
module grp_clk_gate
  import col_sector_pkg::*;
(
  input  logic cfg_valid_i,
  input  logic src_i,
  input  logic col_clk_i,
  input  logic xclk_i,
  input  logic en_i,
  input  logic inv_i,
  output logic grp_clk_o
);
  logic src_clk;
  logic run;

  assign src_clk = (src_sel_e'(src_i) == SRC_EXPRESS) ? xclk_i : col_clk_i;
  // enable and polarity are static config; the AND never cuts a live pulse
  assign run       = cfg_valid_i & en_i;
  assign grp_clk_o = run & (src_clk ^ inv_i);
endmodule

// File: rtl/grp_sr_sel.sv
module grp_sr_sel
  import col_sector_pkg::*;
(
  input  logic cfg_valid_i,
  input  logic src_i,
  input  logic inv_i,
  input  logic gsr_i,
  input  logic xsr_i,
  output logic sr_no
);
  logic raw;

  assign raw   = (src_sel_e'(src_i) == SRC_EXPRESS) ? xsr_i : gsr_i;
  assign sr_no = cfg_valid_i ? (raw ^ inv_i) : 1'b1;
endmodule

// File: rtl/sector_cell.sv
module sector_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sr_ni,
  input  logic mode_i,
  input  logic d_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge sr_ni or negedge rst_ni) begin
    if (!rst_ni)     q_o <= 1'b1;
    else if (!sr_ni) q_o <= mode_i;
    else             q_o <= d_i;
  end
endmodule

// File: rtl/col_sector_ctl.sv
module col_sector_ctl #(
  parameter int N_GCLK   = 8,
  parameter int N_FCLK   = 2,
  parameter int CELLS    = 4,
  parameter bit EDGE_COL = 1'b1,
  parameter int SEL_W    = $clog2(N_GCLK + N_FCLK)
) (
  input  logic              rst_ni,
  input  logic              cfg_valid_i,
  input  logic [SEL_W-1:0]  col_sel_i,
  input  logic              grp_clk_src_i,
  input  logic              clk_en_i,
  input  logic              clk_inv_i,
  input  logic              sr_src_i,
  input  logic              sr_inv_i,
  input  logic [CELLS-1:0]  sr_mode_i,
  input  logic [N_GCLK-1:0] gclk_i,
  input  logic [N_FCLK-1:0] fclk_i,
  input  logic              xclk_i,
  input  logic              gsr_i,
  input  logic              xsr_i,
  input  logic [CELLS-1:0]  d_i,
  output logic [CELLS-1:0]  q_o,
  output logic              cell_clk_o
);
  logic col_clk;
  logic grp_clk;
  logic grp_sr_n;

  col_clk_mux #(
    .N_GCLK(N_GCLK), .N_FCLK(N_FCLK), .EDGE_COL(EDGE_COL), .SEL_W(SEL_W)
  ) u_mux (
    .sel_i(col_sel_i), .gclk_i(gclk_i), .fclk_i(fclk_i), .col_clk_o(col_clk)
  );

  grp_clk_gate u_gate (
    .cfg_valid_i(cfg_valid_i), .src_i(grp_clk_src_i), .col_clk_i(col_clk),
    .xclk_i(xclk_i), .en_i(clk_en_i), .inv_i(clk_inv_i), .grp_clk_o(grp_clk)
  );

  grp_sr_sel u_sr (
    .cfg_valid_i(cfg_valid_i), .src_i(sr_src_i), .inv_i(sr_inv_i),
    .gsr_i(gsr_i), .xsr_i(xsr_i), .sr_no(grp_sr_n)
  );

  generate
    for (genvar k = 0; k < CELLS; k++) begin : g_cell
      sector_cell u_cell (
        .clk_i(grp_clk), .rst_ni(rst_ni), .sr_ni(grp_sr_n),
        .mode_i(sr_mode_i[k]), .d_i(d_i[k]), .q_o(q_o[k])
      );
    end
  endgenerate

  assign cell_clk_o = grp_clk;
endmodule

// File: rtl/col_sector_chk.sv
module col_sector_chk #(
  parameter int N_GCLK   = 8,
  parameter int N_FCLK   = 2,
  parameter int CELLS    = 4,
  parameter bit EDGE_COL = 1'b1,
  parameter int SEL_W    = 4
) (
  input logic              cell_clk_i,
  input logic              rst_ni,
  input logic              cfg_valid_i,
  input logic              clk_en_i,
  input logic              clk_inv_i,
  input logic              grp_clk_src_i,
  input logic [SEL_W-1:0]  col_sel_i,
  input logic [N_GCLK-1:0] gclk_i,
  input logic              xclk_i,
  input logic              sr_n_i,
  input logic [CELLS-1:0]  sr_mode_i,
  input logic [CELLS-1:0]  q_o
);
  localparam int N_IN = col_sector_pkg::sel_count(N_GCLK, N_FCLK, EDGE_COL);

  AST_NO_CLK_UNCFG: assert property (@(posedge cell_clk_i) disable iff (!rst_ni)
    1'b1 |-> cfg_valid_i); // R6
  AST_NO_CLK_GATED: assert property (@(posedge cell_clk_i) disable iff (!rst_ni)
    1'b1 |-> clk_en_i); // R5
  AST_SEL_IN_RANGE: assert property (@(posedge cell_clk_i) disable iff (!rst_ni)
    !grp_clk_src_i |-> (col_sel_i < SEL_W'(N_IN))); // R2
  AST_GCLK_RISE: assert property (@(posedge cell_clk_i) disable iff (!rst_ni)
    (!grp_clk_src_i && !clk_inv_i && col_sel_i < SEL_W'(N_GCLK))
      |-> ((gclk_i >> col_sel_i) & N_GCLK'(1)) == '0); // R1
  AST_XCLK_RISE: assert property (@(posedge cell_clk_i) disable iff (!rst_ni)
    (grp_clk_src_i && !clk_inv_i) |-> !xclk_i); // R3
  AST_XCLK_FALL_INV: assert property (@(posedge cell_clk_i) disable iff (!rst_ni)
    (grp_clk_src_i && clk_inv_i) |-> xclk_i); // R4
  AST_SR_HOLDS: assert property (@(posedge cell_clk_i) disable iff (!rst_ni)
    !sr_n_i |-> (q_o == sr_mode_i)); // R8
endmodule

bind col_sector_ctl col_sector_chk #(
  .N_GCLK(N_GCLK), .N_FCLK(N_FCLK), .CELLS(CELLS), .EDGE_COL(EDGE_COL), .SEL_W(SEL_W)
) u_chk (
  .cell_clk_i(cell_clk_o), .rst_ni(rst_ni), .cfg_valid_i(cfg_valid_i),
  .clk_en_i(clk_en_i), .clk_inv_i(clk_inv_i), .grp_clk_src_i(grp_clk_src_i),
  .col_sel_i(col_sel_i), .gclk_i(gclk_i), .xclk_i(xclk_i), .sr_n_i(grp_sr_n),
  .sr_mode_i(sr_mode_i), .q_o(q_o)
);

// File: tb/sim_col_sector_ctl.sv
module sim_col_sector_ctl;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b1;
  logic       cfg_valid = 1'b0;
  logic [3:0] col_sel = '0;
  logic       grp_src = 1'b0, en = 1'b0, inv = 1'b0, sr_src = 1'b0, sr_inv = 1'b0;
  logic [3:0] mode = '0;
  logic [7:0] gclk = '0;
  logic [1:0] fclk = '0;
  logic       xclk = 1'b0, gsr = 1'b1, xsr = 1'b1;
  logic [3:0] d = '0;
  logic [3:0] q0, q1;
  logic       cc0, cc1;

  int    n_chk = 0, n_fail = 0;
  bit    done = 1'b0;
  string tag = "R9";
  int    sr_pct = 0;

  logic [3:0] mq0 = 4'hF, mq1 = 4'hF;
  logic       pc0 = 1'b0, pc1 = 1'b0;

  always #5 clk = ~clk;

  col_sector_ctl #(.EDGE_COL(1'b1)) u0 (
    .rst_ni(rst_ni), .cfg_valid_i(cfg_valid), .col_sel_i(col_sel),
    .grp_clk_src_i(grp_src), .clk_en_i(en), .clk_inv_i(inv), .sr_src_i(sr_src),
    .sr_inv_i(sr_inv), .sr_mode_i(mode), .gclk_i(gclk), .fclk_i(fclk),
    .xclk_i(xclk), .gsr_i(gsr), .xsr_i(xsr), .d_i(d), .q_o(q0), .cell_clk_o(cc0)
  );

  col_sector_ctl #(.EDGE_COL(1'b0)) u1 (
    .rst_ni(rst_ni), .cfg_valid_i(cfg_valid), .col_sel_i(col_sel),
    .grp_clk_src_i(grp_src), .clk_en_i(en), .clk_inv_i(inv), .sr_src_i(sr_src),
    .sr_inv_i(sr_inv), .sr_mode_i(mode), .gclk_i(gclk), .fclk_i(fclk),
    .xclk_i(xclk), .gsr_i(gsr), .xsr_i(xsr), .d_i(d), .q_o(q1), .cell_clk_o(cc1)
  );

  // reference: expected delivered clock for an edge or interior column
  function automatic logic m_clk(input bit edge_col);
    logic col;
    int   s;
    s   = int'(col_sel);
    col = 1'b0;
    if (s < 8) col = gclk[s[2:0]];
    else if (edge_col && s == 8) col = fclk[0];
    else if (edge_col && s == 9) col = fclk[1];
    if (grp_src) col = xclk;
    return cfg_valid & en & (col ^ inv);
  endfunction

  function automatic logic m_srn();
    if (!cfg_valid) return 1'b1;
    return (sr_src ? xsr : gsr) ^ sr_inv;
  endfunction

  task automatic check(input string what, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%b exp=%b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic upd();
    logic c0, c1, srn;
    srn = m_srn();
    c0  = m_clk(1'b1);
    c1  = m_clk(1'b0);
    for (int k = 0; k < 4; k++) begin
      if (!rst_ni) begin mq0[k] = 1'b1; mq1[k] = 1'b1; end
      else if (!srn) begin mq0[k] = mode[k]; mq1[k] = mode[k]; end
      else begin
        if (c0 && !pc0) mq0[k] = d[k];
        if (c1 && !pc1) mq1[k] = d[k];
      end
    end
    pc0 = c0;
    pc1 = c1;
    check("edge q", q0, mq0);
    check("inner q", q1, mq1);
    check("edge clk", {3'b0, cc0}, {3'b0, c0});
    check("inner clk", {3'b0, cc1}, {3'b0, c1});
  endtask

  // data, then set/reset lines, then clock lines, each settled apart
  task automatic tick();
    logic act, v;
    @(negedge clk);
    d = 4'($urandom);
    #1 upd();
    act = (($urandom % 100) < sr_pct);
    gsr = 1'($urandom);
    xsr = 1'($urandom);
    v   = act ? sr_inv : ~sr_inv;
    if (sr_src) xsr = v; else gsr = v;
    #1 upd();
    gclk = 8'($urandom);
    fclk = 2'($urandom);
    xclk = 1'($urandom);
    #1 upd();
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  // inverted configs must avoid sel 8/9 on the column path (interior column idles high)
  task automatic configure(input int sel, input logic gs, input logic e, input logic iv,
                           input logic ss, input logic si, input logic [3:0] md, input logic valid);
    @(negedge clk);
    cfg_valid = 1'b0;
    #1 upd();
    col_sel = 4'(sel);
    grp_src = gs; en = e; inv = iv; sr_src = ss; sr_inv = si; mode = md;
    gclk = {8{iv}}; fclk = {2{iv}}; xclk = iv;
    #1 upd();
    cfg_valid = valid;
    #1 upd();
  endtask

  task automatic set_rst(input logic v);
    @(negedge clk);
    rst_ni = v;
    #1 upd();
  endtask

  initial begin
    #2 rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    tag = "R9";
    upd();
    check("reset value", q0, 4'hF);
    set_rst(1'b1);

    tag = "R6";
    sr_pct = 60;
    configure(3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'b0000, 1'b0);
    ticks(25);
    check("uncfg hold", q0, 4'hF);
    check("uncfg hold inner", q1, 4'hF);

    tag = "R1";
    sr_pct = 5;
    for (int s = 0; s < 8; s++) begin
      configure(s, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4'b1001, 1'b1);
      ticks(20);
    end

    tag = "R2";
    for (int s = 8; s < 10; s++) begin
      configure(s, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'b0110, 1'b1);
      ticks(30);
    end
    configure(12, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'b0011, 1'b1);
    ticks(20);

    tag = "R3";
    for (int s = 0; s < 10; s += 3) begin
      configure(s, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'b1100, 1'b1);
      ticks(20);
    end

    tag = "R4";
    configure(5, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'b1010, 1'b1);
    ticks(30);
    configure(9, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 4'b0101, 1'b1);
    ticks(30);

    tag = "R5";
    sr_pct = 0;
    configure(2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0000, 1'b1);
    ticks(25);
    configure(0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'b0000, 1'b1);
    ticks(25);

    tag = "R7";
    sr_pct = 40;
    for (int c = 0; c < 4; c++) begin
      configure(1, 1'b0, 1'b1, 1'b0, 1'(c >> 1), 1'(c), 4'b0110, 1'b1);
      ticks(25);
    end

    tag = "R8";
    sr_pct = 100;
    configure(4, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'b1010, 1'b1);
    ticks(20);
    check("forced pattern", q0, 4'b1010);
    configure(8, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'b0101, 1'b1);
    ticks(20);
    check("forced pattern", q0, 4'b0101);
    configure(6, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 4'b0000, 1'b1);
    ticks(10);
    check("all reset", q1, 4'b0000);
    configure(7, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 4'b1111, 1'b1);
    ticks(10);
    check("all set", q1, 4'b1111);

    tag = "R9";
    sr_pct = 30;
    configure(0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'b0000, 1'b1);
    ticks(10);
    set_rst(1'b0);
    check("mid reset", q0, 4'hF);
    ticks(10);
    sr_pct = 0;
    tick();
    set_rst(1'b1);
    ticks(15);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1ms;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog %s act=running exp=finished", tag);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule